// File: doc/BRIEF.md
# Serial Byte Transmitter with Sticky Status Flags

The block sends bytes on a single asynchronous serial line. Each frame has one start bit, eight data bits and one stop bit. A byte written by the host is kept in a one-byte holding register until a ten-bit shifter is free. The shifter advances one bit per pulse on a one-cycle `baud_tick` input, which comes from a baud generator outside the block.

Two sticky status flags report progress. `flag_empty` means the holding register can take a new byte. `flag_done` means the line is idle and nothing is waiting. Both flags are cleared by a two-step handshake: first a status read that sees `flag_empty` set, then a write to the data register. A write without that prior read still stores the byte, but it neither queues the byte nor touches the flags.

The host can also ask for a whole frame of marks (a preamble) or a whole frame of spaces (a break). Each flag has its own interrupt enable, and each interrupt request is that flag gated by its enable.

Top module: `uart_tx_flags`

## Requirements
- R1: After reset, `txd`=1, `flag_empty`=1, `flag_done`=1, and both interrupt enables are 0, so `irq_empty`=0 and `irq_done`=0.
- R2: A data frame puts on `txd` a start bit of 0, then the eight data bits starting with bit 0, then a stop bit of 1. Each bit is held from one `baud_tick` edge to the next. The frame starts on the first `baud_tick` after it is queued.
- R3: The following sequence queues the held byte: a `stat_rd` pulse while `flag_empty`=1, then a later `data_wr` pulse. On the edge of that write, both `flag_empty` and `flag_done` go to 0.
- R4: A `data_wr` that is not armed leaves both flags unchanged and sends nothing, but the byte replaces the held byte. A write is not armed if there was no earlier `stat_rd`, if the `stat_rd` came while `flag_empty`=0, or if another write came after the read.
- R5: `flag_empty` returns to 1 on the `baud_tick` edge where the shifter takes the held byte.
- R6: `flag_done` is 1 exactly when `flag_empty`=1, the shifter is idle and no preamble or break is pending. `flag_done` stays 0 for the whole of every frame. While it is 1, `txd` is 1.
- R7: A `preamble_req` pulse queues a frame of ten 1 bits and clears `flag_done` on the same edge.
- R8: A `break_req` pulse queues a frame of ten 0 bits and clears `flag_done` on the same edge.
- R9: When the shifter becomes free on a tick, it picks the next frame in this order: a pending break, then a pending preamble, then a queued data byte. Frames follow each other with no idle bit between them.
- R10: A `ctl_wr` pulse loads the interrupt enables: `ctl_wdata[0]` enables `irq_empty` and `ctl_wdata[1]` enables `irq_done`. Each request equals its flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| stat_rd | input | 1 | Status register read strobe |
| data_wr | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte written with `data_wr` |
| ctl_wr | input | 1 | Interrupt enable register write strobe |
| ctl_wdata | input | 2 | Enables: bit 0 empty, bit 1 complete |
| preamble_req | input | 1 | Queue a frame of ten marks |
| break_req | input | 1 | Queue a frame of ten spaces |
| txd | output | 1 | Serial output line |
| flag_empty | output | 1 | Holding register empty flag |
| flag_done | output | 1 | Transmission complete flag |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Complete interrupt request |

## Verification
The flags change on the clock edge that samples a strobe, so they can be read just after that edge. The exception is `flag_empty` returning to 1, which is due on the first tick after a byte is queued. Each serial bit appears just after the tick edge that starts it. `flag_done` rises just after the tick that ends the last bit.

The bench applies every strobe away from tick cycles, so load times are known in advance. It reads the flags 2 ns after the edge. A monitor takes expected bits from a queue, compares one at each tick edge, and expects idle marks when the queue is empty.

// File: rtl/uart_tx_flags.sv
module uart_tx_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          stat_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          ctl_wr,
  input  logic [1:0]    ctl_wdata,
  input  logic          preamble_req,
  input  logic          break_req,
  output logic          txd,
  output logic          flag_empty,
  output logic          flag_done,
  output logic          irq_empty,
  output logic          irq_done
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW);

  logic [DW-1:0] hold_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic tdre_q, tc_q, arm_q, en_e_q, en_c_q, pre_q, brk_q, busy_q;

  logic queue_data, last, take, ld_brk, ld_pre, ld_dat, ld_any;
  logic tdre_d, busy_d, pre_d, brk_d;

  assign queue_data = data_wr & arm_q;
  assign last   = busy_q && (cnt_q == CW'(FW-1));
  assign take   = baud_tick && (!busy_q || last);
  assign ld_brk = take && brk_q;
  assign ld_pre = take && !brk_q && pre_q;
  assign ld_dat = take && !brk_q && !pre_q && !tdre_q;
  assign ld_any = ld_brk || ld_pre || ld_dat;

  assign pre_d  = (pre_q && !ld_pre) || preamble_req;
  assign brk_d  = (brk_q && !ld_brk) || break_req;
  assign tdre_d = queue_data ? 1'b0 : (ld_dat ? 1'b1 : tdre_q);
  assign busy_d = ld_any ? 1'b1 : ((baud_tick && last) ? 1'b0 : busy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tdre_q <= 1'b1;
      tc_q   <= 1'b1;
      arm_q  <= 1'b0;
      en_e_q <= 1'b0;
      en_c_q <= 1'b0;
      pre_q  <= 1'b0;
      brk_q  <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else begin
      if (data_wr) hold_q <= wr_data;
      if (data_wr) arm_q <= 1'b0;
      else if (stat_rd && tdre_q) arm_q <= 1'b1;
      if (ctl_wr) begin
        en_e_q <= ctl_wdata[0];
        en_c_q <= ctl_wdata[1];
      end
      tdre_q <= tdre_d;
      pre_q  <= pre_d;
      brk_q  <= brk_d;
      busy_q <= busy_d;
      tc_q   <= tdre_d && !busy_d && !pre_d && !brk_d;
      if (ld_any) begin
        cnt_q <= '0;
        if (ld_brk)      sh_q <= '0;
        else if (ld_pre) sh_q <= '1;
        else             sh_q <= {1'b1, hold_q, 1'b0};
      end else if (baud_tick && busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {1'b1, sh_q[FW-1:1]};
      end
    end
  end

  assign txd        = busy_q ? sh_q[0] : 1'b1;
  assign flag_empty = tdre_q;
  assign flag_done  = tc_q;
  assign irq_empty  = tdre_q & en_e_q;
  assign irq_done   = tc_q & en_c_q;

  assert_idle_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_done |-> txd);
  assert_done_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_done |-> flag_empty);
  assert_empty_clear_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_empty) |-> $past(data_wr));
  assert_empty_set_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_empty) |-> $past(baud_tick));
  assert_req_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (preamble_req || break_req) |=> !flag_done);
  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && brk_q && !busy_q) |=> !txd);
endmodule

// File: tb/uart_tx_flags_bench.sv
module uart_tx_flags_bench;
  logic clk = 0, rst_n = 0, tick = 0;
  logic stat_rd = 0, data_wr = 0, ctl_wr = 0, preamble_req = 0, break_req = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] ctl_wdata = 0;
  logic txd, flag_empty, flag_done, irq_empty, irq_done;
  int errors = 0, checks = 0;
  logic [2:0] tcnt = 0;
  logic exp_q[$];

  uart_tx_flags u_uart_tx_flags (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .stat_rd(stat_rd),
    .data_wr(data_wr), .wr_data(wr_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .preamble_req(preamble_req), .break_req(break_req), .txd(txd),
    .flag_empty(flag_empty), .flag_done(flag_done),
    .irq_empty(irq_empty), .irq_done(irq_done));

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk); #1;
    tcnt = tcnt + 1'b1;
    tick = (tcnt == 3'd0) && rst_n;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial forever begin
    logic tk;
    logic e;
    @(posedge clk);
    tk = tick;
    #3;
    if (tk && rst_n) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
      check("R2/R9 txd bit", txd, e);
    end
  end

  task automatic push_frame(input logic [9:0] f);
    for (int i = 0; i < 10; i++) exp_q.push_back(f[i]);
  endtask

  task automatic prep();
    do begin @(posedge clk); #2; end while (tick);
  endtask

  task automatic rd();
    prep(); stat_rd = 1; @(posedge clk); #2; stat_rd = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    prep(); data_wr = 1; wr_data = d; @(posedge clk); #2; data_wr = 0;
  endtask

  task automatic ctl(input logic [1:0] v);
    prep(); ctl_wr = 1; ctl_wdata = v; @(posedge clk); #2; ctl_wr = 0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
    #2;
  endtask

  task automatic wait_done();
    wait (exp_q.size() == 0);
    wait_ticks(1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #2;
    check("R1 txd", txd, 1);
    check("R1 flag_empty", flag_empty, 1);
    check("R1 flag_done", flag_done, 1);
    check("R1 irq_empty", irq_empty, 0);
    check("R1 irq_done", irq_done, 0);

    ctl(2'b11);
    check("R10 irq_empty on", irq_empty, 1);
    check("R10 irq_done on", irq_done, 1);
    ctl(2'b01);
    check("R10 irq_done gated", irq_done, 0);
    check("R10 irq_empty kept", irq_empty, 1);

    wr(8'h11);
    wait_ticks(3);
    check("R4 no read empty", flag_empty, 1);
    check("R4 no read done", flag_done, 1);

    rd();
    push_frame({1'b1, 8'hA5, 1'b0});
    wr(8'hA5);
    check("R3 empty cleared", flag_empty, 0);
    check("R3 done cleared", flag_done, 0);
    check("R10 irq follows flag", irq_empty, 0);
    wait_ticks(1);
    check("R5 empty on load", flag_empty, 1);
    check("R6 done low in frame", flag_done, 0);

    rd();
    push_frame({1'b1, 8'h3C, 1'b0});
    wr(8'h3C);
    check("R3 second byte queued", flag_empty, 0);
    rd();
    wait (flag_empty === 1'b1);
    @(posedge clk); #2;
    wr(8'h77);
    check("R4 stale read empty", flag_empty, 1);
    wr(8'h78);
    check("R4 repeat write empty", flag_empty, 1);
    wait_done();
    check("R6 done after frames", flag_done, 1);
    check("R6 idle line", txd, 1);

    prep(); preamble_req = 1; @(posedge clk); #2; preamble_req = 0;
    push_frame(10'h3FF);
    check("R7 done cleared", flag_done, 0);
    wait_ticks(4);
    check("R7 done low in preamble", flag_done, 0);
    wait_done();
    check("R7 done after preamble", flag_done, 1);

    prep(); break_req = 1; @(posedge clk); #2; break_req = 0;
    push_frame(10'h000);
    check("R8 done cleared", flag_done, 0);
    wait_ticks(3);
    check("R8 line low", txd, 0);
    wait_done();
    check("R8 done after break", flag_done, 1);

    rd();
    push_frame({1'b1, 8'h5A, 1'b0});
    wr(8'h5A);
    wait_ticks(1);
    rd();
    wr(8'hC3);
    prep(); break_req = 1; preamble_req = 1; @(posedge clk); #2;
    break_req = 0; preamble_req = 0;
    push_frame(10'h000);
    push_frame(10'h3FF);
    push_frame({1'b1, 8'hC3, 1'b0});
    check("R9 data waits", flag_empty, 0);
    wait_done();
    check("R9 empty at end", flag_empty, 1);
    check("R9 done at end", flag_done, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule